// File: doc/BRIEF.md
# Four-Way Instruction Cache Controller

This block is a read-only instruction cache of 1 KB. It sits between a processor fetch port and an external memory read port. It has four ways and sixteen sets of 16-byte lines. A fetch to a cacheable address that finds its line returns the word from local storage. A fetch that misses loads the whole line with a four-beat burst. The word the processor asked for is handed back as soon as its beat arrives. The line is replaced in the way chosen by least-recently-used order within its set.

Four controls shape the behaviour:

- **Lock.** Holding `cache_lock` keeps the current contents resident. A miss is then served by a single-word read, and nothing in the cache changes.
- **Flush.** A one-cycle `cache_flush` pulse invalidates every line. It is meant to be raised when a software breakpoint is planted in code.
- **Enable.** Clearing `cache_en` turns the block into a pass-through and keeps every line invalid.
- **Area select.** `area_sel` chooses the one address window, by the top address bits, whose fetches may be cached.

The fetch side is a hold-until-done handshake. The processor raises `fetch_req` with `fetch_addr` and holds both until `fetch_done` pulses. The memory side is a request/valid interface. `mem_req` stays high with a stable `mem_addr` until the last data beat has been accepted.

Top module: `icache4w`

## Requirements
- R1: Storage is 4 ways by 16 sets by 4 words of 32 bits. The set index is address bits [7:4], the word within the line is bits [3:2], and the tag is bits [31:8]. Lines in different sets never evict each other.
- R2: A fetch that misses, with the cache enabled, unlocked and inside the cacheable area, raises `mem_req` with `mem_burst`=1 at the line-aligned address (bits [3:0] zero). It takes four beats, which fill words 0, 1, 2, 3 of the line in that order.
- R3: During a refill, `fetch_done` pulses with the requested word on the cycle its beat is accepted, so word 3 completes three cycles later than word 0. The line becomes valid only after the fourth beat.
- R4: A fetch that hits raises `fetch_done`, with the stored word, on the second rising edge after `fetch_req` is first sampled high. It raises no memory request.
- R5: A refill picks the lowest-numbered invalid way of the set. If all ways are valid, it picks the least recently used way. Hits and refills both make their way the most recent.
- R6: While `cache_lock` is 1, a miss is served by one single-word read (`mem_burst`=0) at the fetch address. No line is written or replaced, and hits leave the LRU order unchanged.
- R7: A fetch is cacheable only when `fetch_addr[31:28]` equals `area_sel`. Any other fetch is served by a single-word read and never allocates a line.
- R8: A one-cycle `cache_flush` pulse invalidates every line, so each later fetch misses. A refill in progress during the pulse does not validate its line.
- R9: While `cache_en` is 0, every fetch is a single-word read and every valid bit is held clear. After re-enabling, previously cached lines miss.
- R10: `fetch_done` is a one-cycle pulse, and `mem_addr` stays constant while `mem_req` stays high. Out of reset neither `fetch_done` nor `mem_req` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cache_en | input | 1 | Cache enable; 0 bypasses and invalidates |
| cache_lock | input | 1 | Freeze contents and LRU; misses go uncached |
| cache_flush | input | 1 | Pulse that invalidates all lines |
| area_sel | input | 4 | Value of address bits [31:28] that is cacheable |
| fetch_req | input | 1 | Fetch request, held until `fetch_done` |
| fetch_addr | input | 32 | Byte address of the fetch |
| fetch_done | output | 1 | One-cycle completion pulse |
| fetch_data | output | 32 | Fetched word, valid with `fetch_done` |
| mem_req | output | 1 | External read request, held until last beat |
| mem_burst | output | 1 | 1 for a four-beat line read, 0 for one word |
| mem_addr | output | 32 | External read address |
| mem_valid | input | 1 | A data beat is present |
| mem_rdata | input | 32 | Beat data |

## Verification
The main function is exercised with four kinds of fetch pattern:

- **Repeated fetches to one line.** These separate a hit from a miss by the kind of memory request each produces and by the two-cycle hit latency.
- **Fetches to word 0 and word 3 of fresh lines.** These show that the critical word is returned on its own beat and not at the end of the burst.
- **Five lines mapped onto one set, with a hit placed between the fills.** This shows that the LRU way, and not the oldest fill, is evicted. A fetch to a neighbouring set shows that sets stay independent.
- **The same misses and hits repeated under lock, outside the selected area, after a flush and with the cache disabled.** These show that each control alone turns bursts into single reads or hits into misses, and that lock freezes the replacement order.

// File: rtl/icache_pkg.sv
package icache_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_LOOK = 2'd1,
      ST_FILL = 2'd2,
      ST_BYP  = 2'd3
   } ic_state_e;
endpackage

// File: rtl/icache_lru.sv
// Per-set recency ranks: 0 = most recent, WAYS-1 = least recent.
module icache_lru #(
   parameter int SETS = 16,
   parameter int WAYS = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     touch_en,
   input  logic [$clog2(SETS)-1:0]  touch_set,
   input  logic [$clog2(WAYS)-1:0]  touch_way,
   input  logic [$clog2(SETS)-1:0]  q_set,
   output logic [$clog2(WAYS)-1:0]  oldest_way
);
   localparam int SET_W  = $clog2(SETS);
   localparam int RANK_W = $clog2(WAYS);

   if ((1 << RANK_W) != WAYS || WAYS < 2) begin : g_bad_ways
      $error("icache_lru: WAYS must be a power of two of at least 2");
   end
   if ((1 << SET_W) != SETS) begin : g_bad_sets
      $error("icache_lru: SETS must be a power of two");
   end

   logic [RANK_W-1:0] rank_q [SETS][WAYS];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++)
               rank_q[s][w] <= RANK_W'(w);
      end else if (touch_en) begin
         for (int w = 0; w < WAYS; w++) begin
            if (touch_way == RANK_W'(w))
               rank_q[touch_set][w] <= '0;
            else if (rank_q[touch_set][w] < rank_q[touch_set][touch_way])
               rank_q[touch_set][w] <= rank_q[touch_set][w] + 1'b1;
         end
      end
   end

   always_comb begin
      oldest_way = '0;
      for (int w = 0; w < WAYS; w++)
         if (rank_q[q_set][w] == RANK_W'(WAYS - 1))
            oldest_way = RANK_W'(w);
   end
endmodule

// File: rtl/icache_store.sv
// Tag, valid and data arrays with a parallel tag compare for one set.
module icache_store #(
   parameter int SETS   = 16,
   parameter int WAYS   = 4,
   parameter int WORDS  = 4,
   parameter int DATA_W = 32,
   parameter int TAG_W  = 24
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     clear_all,
   input  logic [$clog2(SETS)-1:0]  q_set,
   input  logic [$clog2(WORDS)-1:0] q_word,
   input  logic [TAG_W-1:0]         q_tag,
   output logic [WAYS-1:0]          hit_vec,
   output logic [WAYS-1:0]          valid_vec,
   output logic [DATA_W-1:0]        hit_data,
   input  logic                     wr_en,
   input  logic [$clog2(WAYS)-1:0]  wr_way,
   input  logic [$clog2(WORDS)-1:0] wr_word,
   input  logic [DATA_W-1:0]        wr_data,
   input  logic                     commit_en
);
   localparam int SET_W  = $clog2(SETS);
   localparam int WAY_W  = $clog2(WAYS);
   localparam int WORD_W = $clog2(WORDS);
   localparam int LINES  = SETS * WAYS;
   localparam int ENTRIES = LINES * WORDS;

   if ((1 << WORD_W) != WORDS) begin : g_bad_words
      $error("icache_store: WORDS must be a power of two");
   end

   logic [DATA_W-1:0] data_q  [ENTRIES];
   logic [TAG_W-1:0]  tag_q   [LINES];
   logic [LINES-1:0]  valid_q;

   always_ff @(posedge clk) begin
      if (wr_en)
         data_q[{q_set, wr_way, wr_word}] <= wr_data;
      if (commit_en)
         tag_q[{q_set, wr_way}] <= q_tag;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clear_all)
         valid_q <= '0;
      else if (commit_en)
         valid_q[{q_set, wr_way}] <= 1'b1;
   end

   for (genvar w = 0; w < WAYS; w++) begin : g_way
      logic [SET_W+WAY_W-1:0] line_idx;
      assign line_idx     = {q_set, WAY_W'(w)};
      assign valid_vec[w] = valid_q[line_idx];
      assign hit_vec[w]   = valid_q[line_idx] && (tag_q[line_idx] == q_tag);
   end

   always_comb begin
      hit_data = '0;
      for (int w = 0; w < WAYS; w++)
         if (hit_vec[w])
            hit_data = data_q[{q_set, WAY_W'(w), q_word}];
   end
endmodule

// File: rtl/icache4w.sv
module icache4w #(
   parameter int ADDR_W      = 32,
   parameter int DATA_W      = 32,
   parameter int CACHE_BYTES = 1024,
   parameter int WAYS        = 4,
   parameter int LINE_WORDS  = 4,
   parameter int AREA_W      = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cache_en,
   input  logic              cache_lock,
   input  logic              cache_flush,
   input  logic [AREA_W-1:0] area_sel,
   input  logic              fetch_req,
   input  logic [ADDR_W-1:0] fetch_addr,
   output logic              fetch_done,
   output logic [DATA_W-1:0] fetch_data,
   output logic              mem_req,
   output logic              mem_burst,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_valid,
   input  logic [DATA_W-1:0] mem_rdata
);
   import icache_pkg::*;

   localparam int BYTE_W = $clog2(DATA_W / 8);
   localparam int WORD_W = $clog2(LINE_WORDS);
   localparam int OFF_W  = WORD_W + BYTE_W;
   localparam int SETS   = CACHE_BYTES / (WAYS * LINE_WORDS * (DATA_W / 8));
   localparam int SET_W  = $clog2(SETS);
   localparam int WAY_W  = $clog2(WAYS);
   localparam int TAG_W  = ADDR_W - SET_W - OFF_W;

   if (SETS * WAYS * LINE_WORDS * (DATA_W / 8) != CACHE_BYTES) begin : g_bad_size
      $error("icache4w: CACHE_BYTES does not divide into whole sets");
   end
   if (AREA_W > TAG_W) begin : g_bad_area
      $error("icache4w: AREA_W must fit inside the tag");
   end

   ic_state_e         state_q;
   logic [ADDR_W-1:0] addr_q;
   logic [WORD_W-1:0] beat_q;
   logic [WAY_W-1:0]  victim_q;
   logic              kill_q;
   logic              done_q;
   logic [DATA_W-1:0] rdata_q;
   logic              mreq_q, mburst_q;
   logic [ADDR_W-1:0] maddr_q;

   logic [SET_W-1:0]  q_set;
   logic [WORD_W-1:0] q_word;
   logic [TAG_W-1:0]  q_tag;
   logic              cacheable, hit, last_beat, beat_in;
   logic [WAYS-1:0]   hit_vec, valid_vec;
   logic [DATA_W-1:0] hit_data;
   logic [WAY_W-1:0]  hit_way, oldest_way, victim;
   logic              touch_en, commit_en, found;

   assign q_set     = addr_q[OFF_W +: SET_W];
   assign q_word    = addr_q[BYTE_W +: WORD_W];
   assign q_tag     = addr_q[ADDR_W-1 -: TAG_W];
   assign cacheable = cache_en && (addr_q[ADDR_W-1 -: AREA_W] == area_sel);
   assign hit       = |hit_vec;
   assign beat_in   = (state_q == ST_FILL) && mem_valid;
   assign last_beat = (beat_q == WORD_W'(LINE_WORDS - 1));
   assign commit_en = beat_in && last_beat && !kill_q && !cache_flush && cache_en;
   assign touch_en  = !cache_lock &&
                      (((state_q == ST_LOOK) && cacheable && hit) || (beat_in && last_beat));

   always_comb begin
      hit_way = '0;
      for (int w = 0; w < WAYS; w++)
         if (hit_vec[w]) hit_way = WAY_W'(w);
   end

   always_comb begin
      victim = oldest_way;
      found  = 1'b0;
      for (int w = 0; w < WAYS; w++)
         if (!valid_vec[w] && !found) begin
            victim = WAY_W'(w);
            found  = 1'b1;
         end
   end

   icache_store #(
      .SETS(SETS), .WAYS(WAYS), .WORDS(LINE_WORDS), .DATA_W(DATA_W), .TAG_W(TAG_W)
   ) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear_all (cache_flush || !cache_en),
      .q_set     (q_set),
      .q_word    (q_word),
      .q_tag     (q_tag),
      .hit_vec   (hit_vec),
      .valid_vec (valid_vec),
      .hit_data  (hit_data),
      .wr_en     (beat_in),
      .wr_way    (victim_q),
      .wr_word   (beat_q),
      .wr_data   (mem_rdata),
      .commit_en (commit_en)
   );

   icache_lru #(.SETS(SETS), .WAYS(WAYS)) u_lru (
      .clk        (clk),
      .rst_n      (rst_n),
      .touch_en   (touch_en),
      .touch_set  (q_set),
      .touch_way  ((state_q == ST_FILL) ? victim_q : hit_way),
      .q_set      (q_set),
      .oldest_way (oldest_way)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         addr_q   <= '0;
         beat_q   <= '0;
         victim_q <= '0;
         kill_q   <= 1'b0;
         done_q   <= 1'b0;
         rdata_q  <= '0;
         mreq_q   <= 1'b0;
         mburst_q <= 1'b0;
         maddr_q  <= '0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (fetch_req) begin
                  addr_q  <= fetch_addr;
                  state_q <= ST_LOOK;
               end
            end
            ST_LOOK: begin
               if (cacheable && hit) begin
                  rdata_q <= hit_data;
                  done_q  <= 1'b1;
                  state_q <= ST_IDLE;
               end else if (cacheable && !cache_lock) begin
                  victim_q <= victim;
                  beat_q   <= '0;
                  kill_q   <= 1'b0;
                  mreq_q   <= 1'b1;
                  mburst_q <= 1'b1;
                  maddr_q  <= {addr_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
                  state_q  <= ST_FILL;
               end else begin
                  mreq_q   <= 1'b1;
                  mburst_q <= 1'b0;
                  maddr_q  <= addr_q;
                  state_q  <= ST_BYP;
               end
            end
            ST_FILL: begin
               if (cache_flush) kill_q <= 1'b1;
               if (mem_valid) begin
                  if (beat_q == q_word) begin
                     rdata_q <= mem_rdata;
                     done_q  <= 1'b1;
                  end
                  beat_q <= beat_q + 1'b1;
                  if (last_beat) begin
                     mreq_q  <= 1'b0;
                     state_q <= ST_IDLE;
                  end
               end
            end
            ST_BYP: begin
               if (mem_valid) begin
                  rdata_q <= mem_rdata;
                  done_q  <= 1'b1;
                  mreq_q  <= 1'b0;
                  state_q <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign fetch_done = done_q;
   assign fetch_data = rdata_q;
   assign mem_req    = mreq_q;
   assign mem_burst  = mburst_q;
   assign mem_addr   = maddr_q;
endmodule

// File: rtl/icache4w_chk.sv
module icache4w_chk #(
   parameter int ADDR_W = 32,
   parameter int AREA_W = 4,
   parameter int OFF_W  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cache_en,
   input logic              cache_lock,
   input logic [AREA_W-1:0] area_sel,
   input logic              fetch_done,
   input logic              mem_req,
   input logic              mem_burst,
   input logic [ADDR_W-1:0] mem_addr
);
   assert_burst_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_burst) |-> (mem_addr[OFF_W-1:0] == '0));

   assert_no_burst_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(mem_req) && mem_burst) |-> !$past(cache_lock));

   assert_burst_in_area_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(mem_req) && mem_burst) |-> (mem_addr[ADDR_W-1 -: AREA_W] == $past(area_sel)));

   assert_no_burst_disabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(mem_req) && mem_burst) |-> $past(cache_en));

   assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_done |=> !fetch_done);

   assert_addr_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && $past(mem_req)) |-> $stable(mem_addr));
endmodule

bind icache4w icache4w_chk #(.ADDR_W(ADDR_W), .AREA_W(AREA_W), .OFF_W(OFF_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cache_en   (cache_en),
   .cache_lock (cache_lock),
   .area_sel   (area_sel),
   .fetch_done (fetch_done),
   .mem_req    (mem_req),
   .mem_burst  (mem_burst),
   .mem_addr   (mem_addr)
);

// File: tb/test_icache4w.sv
`timescale 1ns/1ps
module test_icache4w;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cache_en = 1'b1, cache_lock = 1'b0, cache_flush = 1'b0;
   logic [3:0]  area_sel = 4'd0;
   logic        fetch_req = 1'b0;
   logic [31:0] fetch_addr = '0;
   logic        fetch_done;
   logic [31:0] fetch_data;
   logic        mem_req, mem_burst;
   logic [31:0] mem_addr;
   logic        mem_valid = 1'b0;
   logic [31:0] mem_rdata = '0;

   int n_checks = 0, n_fail = 0;
   int n_burst = 0, n_single = 0;
   logic [31:0] last_burst_addr = '0;
   int dbl_done = 0, addr_moves = 0;

   always #2.5 clk = ~clk;

   icache4w i_icache4w (
      .clk(clk), .rst_n(rst_n), .cache_en(cache_en), .cache_lock(cache_lock),
      .cache_flush(cache_flush), .area_sel(area_sel), .fetch_req(fetch_req),
      .fetch_addr(fetch_addr), .fetch_done(fetch_done), .fetch_data(fetch_data),
      .mem_req(mem_req), .mem_burst(mem_burst), .mem_addr(mem_addr),
      .mem_valid(mem_valid), .mem_rdata(mem_rdata)
   );

   function automatic logic [31:0] memval(input logic [31:0] a);
      return {a[31:2], 2'b00} ^ 32'h5A3C_0F96;
   endfunction

   // External memory: one cycle of latency, then 4 or 1 beats on consecutive cycles.
   initial begin
      forever begin
         wait (mem_req === 1'b1);
         begin
            logic [31:0] base;
            int beats;
            base  = mem_addr;
            beats = mem_burst ? 4 : 1;
            if (mem_burst) begin
               n_burst++;
               last_burst_addr = base;
            end else begin
               n_single++;
            end
            @(negedge clk);
            for (int i = 0; i < beats; i++) begin
               @(negedge clk);
               mem_valid = 1'b1;
               mem_rdata = memval(base + 32'(4 * i));
            end
            @(negedge clk);
            mem_valid = 1'b0;
            while (mem_req) @(negedge clk);
         end
      end
   end

   // R10 monitors
   logic        prev_done = 1'b0, prev_req = 1'b0;
   logic [31:0] prev_addr = '0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (fetch_done && prev_done) dbl_done++;
         if (mem_req && prev_req && mem_addr !== prev_addr) addr_moves++;
      end
      prev_done = fetch_done;
      prev_req  = mem_req;
      prev_addr = mem_addr;
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic do_fetch(input logic [31:0] a, output logic [31:0] d, output int cyc);
      @(negedge clk);
      fetch_req  = 1'b1;
      fetch_addr = a;
      cyc = 0;
      d = '0;
      while (cyc < 100) begin
         @(negedge clk);
         cyc++;
         if (fetch_done) break;
      end
      d = fetch_data;
      fetch_req = 1'b0;
      repeat (6) @(negedge clk);
   endtask

   task automatic expect_hit(input logic [31:0] a, input string req);
      logic [31:0] d; int cyc, b0, s0;
      b0 = n_burst; s0 = n_single;
      do_fetch(a, d, cyc);
      check(req, 32'(cyc), 32'd2);
      check(req, 32'(n_burst + n_single), 32'(b0 + s0));
      check(req, d, memval(a));
   endtask

   task automatic expect_burst(input logic [31:0] a, input string req);
      logic [31:0] d; int cyc, b0, s0;
      b0 = n_burst; s0 = n_single;
      do_fetch(a, d, cyc);
      check(req, 32'(n_burst), 32'(b0 + 1));
      check(req, 32'(n_single), 32'(s0));
      check(req, d, memval(a));
   endtask

   task automatic expect_single(input logic [31:0] a, input string req);
      logic [31:0] d; int cyc, b0, s0;
      b0 = n_burst; s0 = n_single;
      do_fetch(a, d, cyc);
      check(req, 32'(n_single), 32'(s0 + 1));
      check(req, 32'(n_burst), 32'(b0));
      check(req, d, memval(a));
   endtask

   task automatic t_reset();
      check("R10 reset done", 32'(fetch_done), 32'd0);
      check("R10 reset mem_req", 32'(mem_req), 32'd0);
   endtask

   task automatic t_fill();
      logic [31:0] d; int c0, c3;
      expect_burst(32'h0000_0108, "R2 miss burst");
      check("R2 line address", last_burst_addr, 32'h0000_0100);
      expect_hit(32'h0000_0100, "R4 hit w0");
      expect_hit(32'h0000_0104, "R4 hit w1");
      expect_hit(32'h0000_010C, "R4 hit w3");
      expect_hit(32'h0000_0108, "R3 line valid after fill");
      do_fetch(32'h0000_0200, d, c0);
      check("R3 critical w0 data", d, memval(32'h0000_0200));
      do_fetch(32'h0000_030C, d, c3);
      check("R3 critical w3 data", d, memval(32'h0000_030C));
      check("R3 critical word timing", 32'(c3 - c0), 32'd3);
   endtask

   task automatic t_lru();
      expect_burst(32'h0000_1010, "R5 fill way0");
      expect_burst(32'h0000_1110, "R5 fill way1");
      expect_burst(32'h0000_1210, "R5 fill way2");
      expect_burst(32'h0000_1310, "R5 fill way3");
      expect_hit  (32'h0000_1010, "R5 touch");
      expect_burst(32'h0000_1410, "R5 evict lru");
      expect_hit  (32'h0000_1010, "R5 touched kept");
      expect_hit  (32'h0000_1210, "R5 kept");
      expect_hit  (32'h0000_1310, "R5 kept");
      expect_hit  (32'h0000_1410, "R5 new line");
      expect_burst(32'h0000_1110, "R5 lru was evicted");
      expect_burst(32'h0000_1020, "R1 other set");
      expect_hit  (32'h0000_1410, "R1 set unaffected");
   endtask

   task automatic t_lock();
      expect_burst(32'h0000_3030, "R6 prep");
      expect_burst(32'h0000_3130, "R6 prep");
      expect_burst(32'h0000_3230, "R6 prep");
      expect_burst(32'h0000_3330, "R6 prep");
      cache_lock = 1'b1;
      expect_hit   (32'h0000_3030, "R6 hit while locked");
      expect_single(32'h0000_3430, "R6 locked miss");
      expect_single(32'h0000_3430, "R6 no allocate");
      cache_lock = 1'b0;
      expect_burst (32'h0000_3530, "R6 refill after unlock");
      expect_hit   (32'h0000_3130, "R6 lru frozen kept");
      expect_burst (32'h0000_3030, "R6 lru frozen evicted");
   endtask

   task automatic t_area();
      expect_single(32'h1000_0040, "R7 outside area");
      expect_single(32'h1000_0040, "R7 never allocated");
      area_sel = 4'd1;
      expect_burst (32'h1000_0040, "R7 inside area");
      expect_hit   (32'h1000_0040, "R7 cached");
      expect_single(32'h0000_0050, "R7 old area bypass");
      area_sel = 4'd0;
   endtask

   task automatic t_flush();
      expect_hit(32'h0000_1410, "R8 before flush");
      @(negedge clk); cache_flush = 1'b1;
      @(negedge clk); cache_flush = 1'b0;
      expect_burst(32'h0000_1410, "R8 miss after flush");
      expect_burst(32'h0000_0100, "R8 other line flushed");
   endtask

   task automatic t_enable();
      expect_hit(32'h0000_0100, "R9 before disable");
      cache_en = 1'b0;
      expect_single(32'h0000_0100, "R9 disabled bypass");
      expect_single(32'h0000_0100, "R9 disabled again");
      cache_en = 1'b1;
      expect_burst(32'h0000_0100, "R9 invalid after enable");
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_fill();
      t_lru();
      t_lock();
      t_area();
      t_flush();
      t_enable();
      check("R10 done pulse width", 32'(dbl_done), 32'd0);
      check("R10 mem_addr stable", 32'(addr_moves), 32'd0);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule